// File: doc/BRIEF.md
# Reset Controller with Interrupt-Then-Reset Hold-Off

This block gathers reset requests from nine system sources and turns them into one system reset pulse of fixed width. The sources are power-on, low-voltage detect, loss of clock, loss of lock, watchdog, external pin, core lockup, software and stop-acknowledge error. Seven of them can be set up so that a request first raises an interrupt and only resets the chip after a selectable number of low-power-oscillator ticks. This gives software time to shut down in an orderly way. The analog detectors and the oscillator sit outside the block. They arrive as one-clock request pulses (`src_req`) and a one-clock tick enable (`lpo_tick`).

Every system reset loads the set of sources that caused it into a last-cause register. It also ORs that set into a sticky register, which keeps causes across resets until software clears them by writing ones. A small register port with write enable, address and data gives access to the configuration and to both cause registers. The asynchronous active-low `rst_n` input stands for power-on reset.

The control path is a state machine with three states. In ST_IDLE a request from any source that may not be delayed takes the transition IDLE→RESET. A request made only of delayable, enabled sources takes IDLE→HOLD. In ST_HOLD the interrupt is raised and ticks are counted. HOLD→RESET is taken on the last tick, or at once when a source that may not be delayed also requests. ST_RESET drives the system reset for a fixed number of clocks, then takes RESET→IDLE.

Top module: `rstc_top`

## Requirements
- R1: After `rst_n` is released, the configuration register reads 0x000, the last-cause and sticky registers both read 0x001 (only the power-on bit), and `irq` and `sys_reset` are low.
- R2: A request from a source whose enable bit is clear, or any request while the global enable (configuration bit 9) is clear, raises `sys_reset` on the clock after the request, and `irq` stays low.
- R3: A request made only of sources whose enable bits are set, with the global enable set, raises `irq` on the next clock while `sys_reset` stays low. `irq` and `sys_reset` are never high together.
- R4: The delay field (configuration bits 11:10) sets the hold-off: 0→8, 1→32, 2→128, 3→512 ticks. Only clocks with `lpo_tick` high are counted. `sys_reset` rises on the clock after the final tick.
- R5: `sys_reset` stays high for exactly 4 clocks each time it is asserted.
- R6: Cause bit positions are 0 power-on, 1 low-voltage, 2 loss of clock, 3 loss of lock, 4 watchdog, 5 pin, 6 lockup, 7 software, 8 stop-acknowledge error. When `sys_reset` rises, the last-cause register (address 1) holds every source that requested from the first request up to that reset.
- R7: The sticky register (address 2) ORs in each reset's causes. Writing a mask to address 2 clears exactly the bits set in the mask. If a cause arrives in the same clock as a clear, the cause wins.
- R8: Power-on and low-voltage requests are never delayed. Their enable bits (configuration bits 0 and 1) always read as zero.
- R9: A request from a non-delayable source during a hold-off cuts the hold short, and `sys_reset` rises on the next clock.
- R10: Requests that arrive while `sys_reset` is high are ignored. They start no further reset and are not recorded.
- R11: The configuration register (address 0) reads back what was written, apart from the bits R8 forces to zero. Writes to the last-cause register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| src_req | input | 9 | One-clock reset request pulse per source, in R6 bit order |
| lpo_tick | input | 1 | Low-power-oscillator tick enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 configuration, 1 last cause, 2 sticky cause |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Read data for `addr`, combinational |
| irq | output | 1 | Reset-pending interrupt, high during the hold-off |
| sys_reset | output | 1 | System reset output |

## Verification
The assertions check the following on every clock:
- `irq` and `sys_reset` are never high together.
- Non-delayable requests reach `sys_reset` one clock later.
- Delayable requests open the hold-off.
- A hold-off without a tick or a new request cannot end.
- The reset pulse is exactly four clocks wide.
- The cause registers are loaded once at the rising edge and stay stable while the reset is high.

Only the bench's scenarios can show the rest:
- The exact hold-off length for each delay code.
- That causes gather during a hold-off.
- That sticky bits clear bit by bit.
- That requests during the reset leave no trace.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NSRC = 9;

    localparam int SRC_POR    = 0;
    localparam int SRC_LVD    = 1;
    localparam int SRC_CLK    = 2;
    localparam int SRC_LOCK   = 3;
    localparam int SRC_WDOG   = 4;
    localparam int SRC_PIN    = 5;
    localparam int SRC_LOCKUP = 6;
    localparam int SRC_SW     = 7;
    localparam int SRC_SACK   = 8;

    // Sources allowed to go through the interrupt-then-reset path.
    localparam logic [NSRC-1:0] DLY_CAPABLE = 9'b1_1111_1100;

    localparam int DSEL_W   = 2;
    localparam int GIE_BIT  = NSRC;
    localparam int DSEL_LSB = NSRC + 1;
    localparam int CFG_W    = NSRC + 1 + DSEL_W;
    localparam int AW       = 2;

    localparam logic [AW-1:0] ADDR_CFG    = 2'd0;
    localparam logic [AW-1:0] ADDR_LAST   = 2'd1;
    localparam logic [AW-1:0] ADDR_STICKY = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RESET = 2'd2
    } rstc_state_e;

endpackage

// File: rtl/rstc_fsm.sv
module rstc_fsm
    import rstc_pkg::*;
#(
    parameter int RST_HOLD  = 4,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req,
    input  logic              lpo_tick,
    input  logic [NSRC-1:0]   src_en,
    input  logic              gie,
    input  logic [DSEL_W-1:0] dsel,
    output logic              irq,
    output logic              sys_reset,
    output logic              cause_load,
    output logic [NSRC-1:0]   cause
);

    localparam int MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * ((1 << DSEL_W) - 1);
    localparam int CNT_W    = MAX_LOG2 + 1;
    localparam int HOLD_W   = $clog2(RST_HOLD + 1);

    rstc_state_e       state_q, state_d;
    logic [CNT_W-1:0]  dly_cnt_q, dly_lim_q;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [NSRC-1:0]   cause_q, cause_acc, eff_en;
    logic              imm_req, any_req, tick_last;

    function automatic logic [CNT_W-1:0] lim_of(input logic [DSEL_W-1:0] s);
        lim_of = CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * int'(s));
    endfunction

    always_comb begin
        eff_en    = gie ? (src_en & DLY_CAPABLE) : '0;
        any_req   = |req;
        imm_req   = |(req & ~eff_en);
        cause_acc = (state_q == ST_HOLD) ? (cause_q | req) : req;
        tick_last = lpo_tick && (dly_cnt_q == (dly_lim_q - CNT_W'(1)));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (imm_req)      state_d = ST_RESET;
                else if (any_req) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (imm_req || tick_last) state_d = ST_RESET;
            end
            ST_RESET: begin
                if (hold_cnt_q == HOLD_W'(RST_HOLD - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and cause accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_cnt_q  <= '0;
            dly_lim_q  <= '0;
            hold_cnt_q <= '0;
            cause_q    <= '0;
        end else begin
            if (state_q == ST_HOLD) begin
                if (lpo_tick) dly_cnt_q <= dly_cnt_q + CNT_W'(1);
            end else begin
                dly_cnt_q <= '0;
            end
            if (state_q == ST_IDLE) dly_lim_q <= lim_of(dsel);
            hold_cnt_q <= (state_q == ST_RESET) ? hold_cnt_q + HOLD_W'(1) : '0;
            cause_q    <= (state_q == ST_RESET) ? '0 : cause_acc;
        end
    end

    // outputs
    always_comb begin
        irq        = (state_q == ST_HOLD);
        sys_reset  = (state_q == ST_RESET);
        cause_load = (state_d == ST_RESET) && (state_q != ST_RESET);
        cause      = cause_acc;
    end

endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             cause_load,
    input  logic [NSRC-1:0]  cause,
    output logic [CFG_W-1:0] cfg_q,
    output logic [NSRC-1:0]  last_q,
    output logic [NSRC-1:0]  sticky_q
);

    localparam logic [CFG_W-1:0] CFG_WMASK = {{DSEL_W{1'b1}}, 1'b1, DLY_CAPABLE};
    localparam logic [NSRC-1:0]  POR_ONLY  = NSRC'(1) << SRC_POR;

    logic [NSRC-1:0] clr_mask, set_mask;

    always_comb begin
        clr_mask = (wr_en && addr == ADDR_STICKY) ? wdata[NSRC-1:0] : '0;
        set_mask = cause_load ? cause : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            last_q   <= POR_ONLY;
            sticky_q <= POR_ONLY;
        end else begin
            if (wr_en && addr == ADDR_CFG) cfg_q <= wdata & CFG_WMASK;
            if (cause_load) last_q <= cause;
            sticky_q <= (sticky_q & ~clr_mask) | set_mask;
        end
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int RST_HOLD  = 4,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             lpo_tick,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             irq,
    output logic             sys_reset
);

    logic [CFG_W-1:0] cfg_w;
    logic [NSRC-1:0]  last_w, sticky_w, cause_w;
    logic             load_w;

    rstc_fsm #(
        .RST_HOLD (RST_HOLD),
        .BASE_LOG2(BASE_LOG2),
        .STEP_LOG2(STEP_LOG2)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (src_req),
        .lpo_tick  (lpo_tick),
        .src_en    (cfg_w[NSRC-1:0]),
        .gie       (cfg_w[GIE_BIT]),
        .dsel      (cfg_w[DSEL_LSB +: DSEL_W]),
        .irq       (irq),
        .sys_reset (sys_reset),
        .cause_load(load_w),
        .cause     (cause_w)
    );

    rstc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cause_load(load_w),
        .cause     (cause_w),
        .cfg_q     (cfg_w),
        .last_q    (last_w),
        .sticky_q  (sticky_w)
    );

    always_comb begin
        case (addr)
            ADDR_CFG:    rdata = cfg_w;
            ADDR_LAST:   rdata = CFG_W'(last_w);
            ADDR_STICKY: rdata = CFG_W'(sticky_w);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] req,
    input logic            lpo_tick,
    input logic            irq,
    input logic            sys_reset,
    input logic [NSRC:0]   en_cfg,
    input logic [NSRC-1:0] last,
    input logic [NSRC-1:0] sticky
);

    logic [NSRC-1:0] eff;
    logic            imm, dly_only;
    int              hi_cnt;

    always_comb begin
        eff      = en_cfg[GIE_BIT] ? (en_cfg[NSRC-1:0] & DLY_CAPABLE) : '0;
        imm      = |(req & ~eff);
        dly_only = (req != '0) && !imm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= 0;
        else        hi_cnt <= sys_reset ? hi_cnt + 1 : 0;
    end

    a_r3_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && sys_reset));

    a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (imm && !sys_reset) |=> sys_reset);

    a_r3_holdoff_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_only && !irq && !sys_reset) |=> (irq && !sys_reset));

    a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !lpo_tick && req == '0) |=> (irq && !sys_reset));

    a_r5_width_max: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> (hi_cnt < RST_HOLD));

    a_r5_width_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset) |-> (hi_cnt == RST_HOLD));

    a_r6_cause_present: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset) |-> (last != '0));

    a_r7_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset) |-> ((last & ~sticky) == '0));

    a_r10_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset && $past(sys_reset)) |-> $stable(last));

endmodule

bind rstc_top rstc_checker #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (src_req),
    .lpo_tick (lpo_tick),
    .irq      (irq),
    .sys_reset(sys_reset),
    .en_cfg   (cfg_w[rstc_pkg::NSRC:0]),
    .last     (last_w),
    .sticky   (sticky_w)
);

// File: tb/rstc_top_bench.sv
module rstc_top_bench;
    import rstc_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_req = '0;
    logic             lpo_tick = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [CFG_W-1:0] wdata = '0;
    logic [CFG_W-1:0] rdata;
    logic             irq, sys_reset;

    rstc_top u_rstc_top (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .lpo_tick(lpo_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .sys_reset(sys_reset)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    lat;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int req_cyc = 0;
    bit done    = 0;
    logic [NSRC-1:0] exp_sticky;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reset events, checks latency and pulse width
    int  hi   = 0;
    bit  prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sys_reset && !prev) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected reset", 1, 0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(it.tag, cyc - req_cyc, it.lat);
                end
            end
            if (sys_reset) hi++;
            else if (prev) begin
                check("R5 reset width", hi, 4);
                hi = 0;
            end
            prev = sys_reset;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [CFG_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [CFG_W-1:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait_idle();
        repeat (6) @(negedge clk);
        check("R5 reset released", sys_reset, 0);
    endtask

    task automatic fire_now(input logic [NSRC-1:0] m, input string tag,
                            input logic [NSRC-1:0] late);
        @(negedge clk);
        src_req = m; req_cyc = cyc;
        exp_q.push_back('{1, tag});
        @(negedge clk);
        src_req = late;   // lands while reset is high (R10)
        check({tag, " irq low"}, irq, 0);
        check({tag, " reset next clock"}, sys_reset, 1);
        @(negedge clk);
        src_req = '0;
        wait_idle();
    endtask

    task automatic fire_delayed(input logic [NSRC-1:0] m, input int n, input int gap,
                                input logic [NSRC-1:0] extra, input string tag);
        @(negedge clk);
        src_req = m; req_cyc = cyc;
        exp_q.push_back('{1 + n * (gap + 1), tag});
        @(negedge clk);
        src_req = '0;
        check("R3 irq raised", irq, 1);
        check("R3 reset held off", sys_reset, 0);
        for (int k = 1; k <= n; k++) begin
            for (int g = 0; g < gap; g++) begin
                lpo_tick = 1'b0;
                @(negedge clk);
            end
            if (k == 3) src_req = extra;
            if (k == n) check({tag, " no early reset"}, {irq, sys_reset}, 2'b10);
            lpo_tick = 1'b1;
            @(negedge clk);
            lpo_tick = 1'b0;
            src_req  = '0;
        end
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADDR_CFG, 12'h000, "R1 cfg");
        rd(ADDR_LAST, 12'h001, "R1 last");
        rd(ADDR_STICKY, 12'h001, "R1 sticky");
        check("R1 outputs", {irq, sys_reset}, 2'b00);
        exp_sticky = 9'h001;

        // R11 / R8 configuration readback, last register read-only
        wr(ADDR_CFG, 12'hBFF);
        rd(ADDR_CFG, 12'hBFC, "R11 R8 cfg readback");
        wr(ADDR_LAST, 12'hFFF);
        rd(ADDR_LAST, 12'h001, "R11 last write ignored");

        // R2 enables clear
        wr(ADDR_CFG, 12'h000);
        fire_now(9'h010, "R2 wdog immediate", '0);
        exp_sticky |= 9'h010;
        rd(ADDR_LAST, 12'h010, "R6 last wdog");
        rd(ADDR_STICKY, CFG_W'(exp_sticky), "R7 sticky or");

        // R2 global enable clear
        wr(ADDR_CFG, 12'h1FF);
        fire_now(9'h080, "R2 gie clear immediate", '0);
        exp_sticky |= 9'h080;
        rd(ADDR_LAST, 12'h080, "R6 last sw");

        // R8 low-voltage never delayed
        wr(ADDR_CFG, 12'h3FF);
        fire_now(9'h002, "R8 lvd immediate", '0);
        exp_sticky |= 9'h002;
        rd(ADDR_LAST, 12'h002, "R8 last lvd");

        // R3 R4 R6 delay code 0, tick every other clock, extra cause accumulates
        fire_delayed(9'h020, 8, 1, 9'h100, "R4 delay 8");
        exp_sticky |= 9'h120;
        rd(ADDR_LAST, 12'h120, "R6 accumulated cause");
        rd(ADDR_STICKY, CFG_W'(exp_sticky), "R7 sticky after hold");

        // R7 partial clear
        wr(ADDR_STICKY, 12'h030);
        exp_sticky &= ~9'h030;
        rd(ADDR_STICKY, CFG_W'(exp_sticky), "R7 mask clear");

        // R4 other delay codes
        wr(ADDR_CFG, 12'h7FF);
        fire_delayed(9'h040, 32, 0, '0, "R4 delay 32");
        exp_sticky |= 9'h040;
        rd(ADDR_LAST, 12'h040, "R6 last lockup");
        wr(ADDR_CFG, 12'hBFF);
        fire_delayed(9'h004, 128, 0, '0, "R4 delay 128");
        exp_sticky |= 9'h004;
        rd(ADDR_LAST, 12'h004, "R6 last clk loss");
        wr(ADDR_CFG, 12'hFFF);
        fire_delayed(9'h008, 512, 0, '0, "R4 delay 512");
        exp_sticky |= 9'h008;
        rd(ADDR_LAST, 12'h008, "R6 last lock loss");

        // R2 per-source enable: only watchdog enabled, pin is immediate
        wr(ADDR_CFG, 12'h210);
        fire_now(9'h020, "R2 pin not enabled", '0);
        exp_sticky |= 9'h020;
        rd(ADDR_LAST, 12'h020, "R6 last pin");

        // R9 pre-emption: watchdog hold-off cut short by low-voltage
        wr(ADDR_CFG, 12'h3FF);
        @(negedge clk);
        src_req = 9'h010; req_cyc = cyc;
        exp_q.push_back('{4, "R9 preempt latency"});
        @(negedge clk);
        src_req = '0; lpo_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        lpo_tick = 1'b0; src_req = 9'h002;
        @(negedge clk);
        src_req = '0;
        check("R9 reset after preempt", sys_reset, 1);
        wait_idle();
        exp_sticky |= 9'h012;
        rd(ADDR_LAST, 12'h012, "R9 last preempt");
        rd(ADDR_STICKY, CFG_W'(exp_sticky), "R7 sticky all");

        // R7 clear everything, then R10 request during reset
        wr(ADDR_STICKY, 12'h1FF);
        rd(ADDR_STICKY, 12'h000, "R7 clear all");
        wr(ADDR_CFG, 12'h000);
        fire_now(9'h080, "R10 sw immediate", 9'h020);
        rd(ADDR_LAST, 12'h080, "R10 last ignores late req");
        rd(ADDR_STICKY, 12'h080, "R10 sticky ignores late req");

        repeat (10) @(negedge clk);
        check("R10 no pending reset", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule